// File: doc/BRIEF.md
# Punch-in crossfader with output gain

This block sits in the playback path of a multichannel recorder. For every channel, two playback subchannels arrive with each sample. They are blended into one playback signal so that edit events change over smoothly. That playback signal is then blended with the live input, so that punching recording in and out leaves no glitch. The result is scaled by an output gain, rounded, and clipped to the 24-bit signed range before it leaves for the time-multiplexed output.

Samples arrive one at a time with a valid strobe and a channel index. Two control bits come with each sample: the subchannel select and the punch state. Each blend follows a linear ramp. Its blend factor k, an unsigned fraction in which 65536 stands for 1.0, moves one step toward its target with every sample of that channel. Ramp state is kept per channel. Because a ramp only moves toward the current target, a change of target in the middle of a ramp turns it back from where it stands.

Top module: `punch_xfade`

## Requirements
- R1: After reset `out_valid` is 0, `out_data` is 0 and every blend factor is 0. A first sample sent with select 0 and punch 0 at unity gain leaves as subchannel A unchanged.
- R2: `out_valid` rises one clock after a sample with `in_valid` high. The same clock presents `out_ch` equal to that sample's `in_ch`, together with its result.
- R3: Playback equals round((A*(65536-ke) + B*ke) / 65536), where ke is the event factor of the channel. ke moves toward 65536 while `in_sub_sel`=1 and toward 0 while it is 0.
- R4: The mix equals round((P*(65536-kp) + L*kp) / 65536), where P is the playback, L is `in_live` and kp is the punch factor. kp moves toward 65536 while `in_punch`=1 (recording) and toward 0 while it is 0.
- R5: Each factor moves by 65536 >> `ramp_shift` per sample of its channel, and it is clamped to the range 0 to 65536. The factor in effect for a sample is the one after that sample's step, so a full ramp ends exactly on the 2^`ramp_shift`-th sample.
- R6: A sample for one channel leaves the factors of every other channel unchanged.
- R7: A change of target in the middle of a ramp reverses the ramp from its current factor. The factor never moves by more than one step per sample.
- R8: Every blend product and the gain product is rounded half toward plus infinity.
- R9: `gain` is unsigned with GF=12 fraction bits, so 4096 is unity. The output is round(mix*gain/4096).
- R10: A scaled result above 8388607 leaves as 8388607, and one below -8388608 leaves as -8388608.
- R11: A `ramp_shift` of 0 switches a factor in one sample. Values above 16 act as 16, which gives a step of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | CW | Channel index of the sample |
| in_live | input | DW | Live input sample, signed |
| in_sub_a | input | DW | Playback subchannel A, signed |
| in_sub_b | input | DW | Playback subchannel B, signed |
| in_sub_sel | input | 1 | Event target: 0 selects A, 1 selects B |
| in_punch | input | 1 | Punch state: 1 selects live input |
| ramp_shift | input | 5 | Ramp length is 2^ramp_shift samples |
| gain | input | GW | Output gain, unsigned, GF fraction bits |
| out_valid | output | 1 | Result strobe |
| out_ch | output | CW | Channel index of the result |
| out_data | output | DW | Scaled, saturated result, signed |

## Verification
The bench builds the block with CHANNELS=4 and keeps the default 24-bit data and Q4.12 gain. Four channels keep the two-bit index small, yet they still let samples interleave across channels in different ramp phases. The ramp length is set at run time, so short ramps of 2, 4 and 8 samples reach both ends of a ramp and a mid-ramp reversal in a few samples. Shifts of 0 and 20 cover the single-step and clamped extremes.

// File: rtl/punch_xfade.sv
module punch_xfade #(
  parameter int CHANNELS = 16,
  parameter int DW       = 24,
  parameter int GW       = 16,
  parameter int GF       = 12,
  localparam int CW      = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [CW-1:0]        in_ch,
  input  logic signed [DW-1:0] in_live,
  input  logic signed [DW-1:0] in_sub_a,
  input  logic signed [DW-1:0] in_sub_b,
  input  logic                 in_sub_sel,
  input  logic                 in_punch,
  input  logic [4:0]           ramp_shift,
  input  logic [GW-1:0]        gain,
  output logic                 out_valid,
  output logic [CW-1:0]        out_ch,
  output logic signed [DW-1:0] out_data
);

  localparam logic [16:0] FULL = 17'h10000;
  localparam int AW = DW + 19;
  localparam int PW = DW + GW + 2;
  localparam logic signed [PW-1:0] SMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] SMIN = ~SMAX;
  localparam logic signed [PW-1:0] GRND = PW'(1) <<< (GF - 1);

  logic [16:0] k_ev [CHANNELS];
  logic [16:0] k_pn [CHANNELS];

  function automatic logic [16:0] advance(input logic [16:0] cur, input logic tgt,
                                          input logic [16:0] stp);
    if (tgt) advance = (cur > FULL - stp) ? FULL : cur + stp;
    else     advance = (cur < stp) ? 17'd0 : cur - stp;
  endfunction

  function automatic logic signed [DW-1:0] blend(input logic signed [DW-1:0] a,
                                                 input logic signed [DW-1:0] b,
                                                 input logic [16:0] k);
    logic signed [AW-1:0] acc;
    acc = AW'(a) * $signed({1'b0, FULL - k}) + AW'(b) * $signed({1'b0, k})
          + AW'(32768);
    blend = acc[DW+15:16];
  endfunction

  logic [4:0]           sh;
  logic [16:0]          step;
  logic [16:0]          cur_ev, cur_pn, nxt_ev, nxt_pn;
  logic signed [DW-1:0] pb, mx;
  logic signed [PW-1:0] prod, scaled, clipped;

  assign sh     = (ramp_shift > 5'd16) ? 5'd16 : ramp_shift;
  assign step   = FULL >> sh;
  assign cur_ev = k_ev[in_ch];
  assign cur_pn = k_pn[in_ch];
  assign nxt_ev = advance(cur_ev, in_sub_sel, step);
  assign nxt_pn = advance(cur_pn, in_punch, step);
  assign pb     = blend(in_sub_a, in_sub_b, nxt_ev);
  assign mx     = blend(pb, in_live, nxt_pn);
  assign prod   = PW'(mx) * $signed({1'b0, gain}) + GRND;
  assign scaled = prod >>> GF;
  assign clipped = (scaled > SMAX) ? SMAX : (scaled < SMIN) ? SMIN : scaled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
      for (int i = 0; i < CHANNELS; i++) begin
        k_ev[i] <= '0;
        k_pn[i] <= '0;
      end
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ch       <= in_ch;
        out_data     <= clipped[DW-1:0];
        k_ev[in_ch]  <= nxt_ev;
        k_pn[in_ch]  <= nxt_pn;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && out_ch == $past(in_ch));

  assert_unity_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && gain == GW'(1 << GF) && k_ev[in_ch] == 0 && k_pn[in_ch] == 0
    && !in_sub_sel && !in_punch |=> out_data == $past(in_sub_a));

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
    assert_k_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      k_ev[g] <= FULL && k_pn[g] <= FULL);

    assert_k_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ch == CW'(g)) |=> $stable(k_ev[g]) && $stable(k_pn[g]));

    assert_no_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ch == CW'(g) |=>
        ((k_pn[g] >= $past(k_pn[g])) ? (k_pn[g] - $past(k_pn[g]))
                                     : ($past(k_pn[g]) - k_pn[g])) <= $past(step)
        && ((k_ev[g] >= $past(k_ev[g])) ? (k_ev[g] - $past(k_ev[g]))
                                        : ($past(k_ev[g]) - k_ev[g])) <= $past(step));
  end

endmodule

// File: tb/sim_punch_xfade.sv
module sim_punch_xfade;
  localparam int CH = 4;

  logic               clk = 0;
  logic               rst_n = 0;
  logic               in_valid = 0;
  logic [1:0]         in_ch = 0;
  logic signed [23:0] in_live = 0, in_sub_a = 0, in_sub_b = 0;
  logic               in_sub_sel = 0, in_punch = 0;
  logic [4:0]         ramp_shift = 5'd8;
  logic [15:0]        gain = 16'd4096;
  logic               out_valid;
  logic [1:0]         out_ch;
  logic signed [23:0] out_data;

  int errors = 0;
  int checks = 0;
  longint mk_ev [CH];
  longint mk_pn [CH];

  always #4 clk = ~clk;

  punch_xfade #(.CHANNELS(CH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
    .in_live(in_live), .in_sub_a(in_sub_a), .in_sub_b(in_sub_b),
    .in_sub_sel(in_sub_sel), .in_punch(in_punch), .ramp_shift(ramp_shift),
    .gain(gain), .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mstep();
    int s = (ramp_shift > 16) ? 16 : int'(ramp_shift);
    return longint'(65536) >> s;
  endfunction

  function automatic longint madv(longint k, bit tgt);
    longint st = mstep();
    if (tgt) return (k + st > 65536) ? 65536 : k + st;
    return (k < st) ? 0 : k - st;
  endfunction

  function automatic longint mbl(longint a, longint b, longint k);
    return (a * (65536 - k) + b * k + 32768) >>> 16;
  endfunction

  function automatic longint mgain(longint m);
    longint v = (m * longint'(gain) + 2048) >>> 12;
    if (v > 8388607) v = 8388607;
    if (v < -8388608) v = -8388608;
    return v;
  endfunction

  // sends one sample, checks against the model, returns the output
  task automatic send(input int ch, input longint live, input longint a, input longint b,
                      input bit punch, input bit sel, input string req, output longint got);
    longint exp;
    @(negedge clk);
    in_valid = 1; in_ch = 2'(ch); in_live = 24'(live); in_sub_a = 24'(a);
    in_sub_b = 24'(b); in_punch = punch; in_sub_sel = sel;
    mk_ev[ch] = madv(mk_ev[ch], sel);
    mk_pn[ch] = madv(mk_pn[ch], punch);
    exp = mgain(mbl(mbl(a, b, mk_ev[ch]), live, mk_pn[ch]));
    @(negedge clk);
    in_valid = 0;
    check({req, " valid (R2)"}, longint'(out_valid), 1);
    check({req, " channel (R2)"}, longint'(out_ch), ch);
    check(req, longint'(out_data), exp);
    got = longint'(out_data);
  endtask

  task automatic t_reset;
    longint r;
    @(negedge clk);
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_data after reset", longint'(out_data), 0);
    send(0, 55, 1234, -999, 0, 0, "R1 first sample", r);
    check("R1 first sample is sub A", r, 1234);
  endtask

  task automatic t_reversal;
    longint r;
    ramp_shift = 5'd3;
    for (int i = 0; i < 3; i++) send(0, 1000, 0, 0, 1, 0, "R7 punch in", r);
    check("R7 partial ramp level", r, 375);
    send(0, 1000, 0, 0, 0, 0, "R7 reversal", r);
    check("R7 reversal steps back one step", r, 250);
    send(0, 1000, 0, 0, 0, 0, "R7 reversal continues", r);
    check("R7 reversal continues", r, 125);
  endtask

  task automatic t_event_ramp;
    longint r;
    ramp_shift = 5'd2;
    for (int i = 0; i < 4; i++) send(1, 0, 1000, -1000, 0, 1, "R3 event ramp", r);
    check("R5 event ramp ends on 4th sample", r, -1000);
    send(1, 0, 1000, -1000, 0, 1, "R5 event ramp held", r);
    check("R5 held at B", r, -1000);
  endtask

  task automatic t_punch_ramp;
    longint r;
    ramp_shift = 5'd3;
    for (int i = 0; i < 8; i++) send(2, -40000, 30000, 7, 1, 0, "R4 punch ramp", r);
    check("R4 punch ramp ends on live", r, -40000);
  endtask

  task automatic t_channels;
    longint r;
    ramp_shift = 5'd2;
    for (int i = 0; i < 3; i++) begin
      send(3, 500, -800, 800, 1, 1, "R6 ch3 ramps", r);
      send(1, 0, 1000, -1000, 0, 0, "R6 ch1 returns", r);
    end
    send(2, -40000, 30000, 7, 1, 0, "R6 ch2 untouched", r);
    check("R6 ch2 still on live", r, -40000);
  endtask

  task automatic t_rounding;
    longint r;
    ramp_shift = 5'd1;
    send(2, 2, 1, 1, 0, 0, "R8 half up positive", r);
    check("R8 blend 1,2 at half", r, 2);
    send(2, 0, 0, 0, 1, 0, "R8 back to live", r);
    send(2, -2, -1, -1, 0, 0, "R8 half up negative", r);
    check("R8 blend -1,-2 at half", r, -1);
    send(2, 0, 0, 0, 1, 0, "R8 back to live", r);
    gain = 16'd2048;
    send(2, 3, 0, 0, 1, 0, "R9 half gain positive", r);
    check("R8 gain round 3*0.5", r, 2);
    send(2, -3, 0, 0, 1, 0, "R9 half gain negative", r);
    check("R8 gain round -3*0.5", r, -1);
    gain = 16'd8192;
    send(2, 600000, 0, 0, 1, 0, "R9 double gain", r);
    check("R9 gain 2.0", r, 1200000);
  endtask

  task automatic t_saturation;
    longint r;
    gain = 16'hFFFF;
    send(2, 8388607, 0, 0, 1, 0, "R10 positive clip", r);
    check("R10 clip high", r, 8388607);
    send(2, -8388608, 0, 0, 1, 0, "R10 negative clip", r);
    check("R10 clip low", r, -8388608);
    gain = 16'd4096;
  endtask

  task automatic t_instant;
    longint r;
    ramp_shift = 5'd0;
    send(3, 0, 100, 200, 0, 0, "R11 instant to A", r);
    check("R11 shift 0 jumps", r, 100);
    send(3, 0, 100, 200, 0, 1, "R11 instant to B", r);
    check("R11 shift 0 jumps to B", r, 200);
    ramp_shift = 5'd20;
    send(3, 0, 0, 65536, 0, 0, "R11 clamped shift", r);
    check("R11 shift 20 steps by 1", r, 65535);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < CH; i++) begin mk_ev[i] = 0; mk_pn[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_reversal();
    t_event_ramp();
    t_punch_ramp();
    t_channels();
    t_rounding();
    t_saturation();
    t_instant();
    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule